// File: doc/BRIEF.md
# Dual Prescaled Clock-Enable Generator

This block produces two independent clock-enable strobes, A and B, on the master clock domain. PWM channels use them as slow time bases. Each path divides the master clock in two stages. The first stage is a power-of-two prescaler whose select value n gives a division by 2^n. The second stage is an 8-bit linear divider. The strobe period is therefore 2^n × D master cycles. No derived clock is created: each output is a one-cycle-wide enable pulse.

A single 32-bit configuration word sets both paths. It is written through a plain write port and can be read back at any time. A divide factor of zero switches a path off, and so does a reserved prescaler select. Every write restarts both paths from zero, so a new rate takes effect with a full first interval. Reset clears the word, which leaves both paths silent.

Top module: `pwm_clk_enable_gen`

## Requirements
- R1: After reset the configuration word reads 0 and neither strobe fires until a write enables a path.
- R2: Path A takes its divide factor from bits 7:0 and its prescaler select from bits 11:8 of the word. The readback returns these bits as written, one cycle after the write.
- R3: Path B takes its divide factor from bits 23:16 and its prescaler select from bits 27:24. Bits 15:12 and 31:28 are not stored and read as 0.
- R4: For a select n in 0..10 and a divide D in 1..255, the strobe of a path fires P = 2^n × D cycles after the write edge, and every P cycles after that.
- R5: Each strobe is high for exactly one master cycle per period. The single exception is P = 1, where it stays high on every cycle.
- R6: A divide factor of 0 keeps the path's strobe low.
- R7: A prescaler select of 11 to 15 keeps the path's strobe low.
- R8: A write clears both paths' counters and strobes. No strobe is high in the cycle after the write edge, and the next interval is a full P, even when the same value is written again.
- R9: The two paths count independently, so the rate of one does not change the timing of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Stored configuration word (unused bits 0) |
| tick_a | output | 1 | Clock-enable strobe of path A |
| tick_b | output | 1 | Clock-enable strobe of path B |

## Verification
The assertions check on every cycle:
- the silence of a path whose divide factor is zero or whose prescaler select is reserved;
- the absence of strobes right after reset or a write;
- the one-cycle width of a strobe whenever the period exceeds one cycle;
- the readback of the field bits.

Only the bench's scenarios can show the exact period 2^n × D and the full first interval after a rewrite. They also show the independence of the two paths and the top prescaler setting. For these, the bench predicts every strobe cycle and compares it with the observed pulses.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int WORD_W    = 32;
    localparam int DIV_W     = 8;
    localparam int SEL_W     = 4;
    localparam int SEL_MAX   = 10;
    localparam int PRE_CNT_W = SEL_MAX;
    localparam int NUM_PATHS = 2;

    localparam int A_DIV_LSB = 0;
    localparam int A_SEL_LSB = 8;
    localparam int B_DIV_LSB = 16;
    localparam int B_SEL_LSB = 24;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } path_cfg_t;

    function automatic logic path_enabled(input path_cfg_t c);
        return (c.div != '0) && (c.sel <= SEL_W'(SEL_MAX));
    endfunction

    function automatic logic [PRE_CNT_W-1:0] pre_last(input logic [SEL_W-1:0] sel);
        logic [31:0] full;
        if (sel > SEL_W'(SEL_MAX)) begin
            full = 32'd0;
        end else begin
            full = (32'd1 << sel) - 32'd1;
        end
        return full[PRE_CNT_W-1:0];
    endfunction

    function automatic int div_lsb(input int idx);
        return (idx == 0) ? A_DIV_LSB : B_DIV_LSB;
    endfunction

    function automatic int sel_lsb(input int idx);
        return (idx == 0) ? A_SEL_LSB : B_SEL_LSB;
    endfunction

endpackage

// File: rtl/clkgen_mode_reg.sv
module clkgen_mode_reg
    import clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output path_cfg_t         cfg [NUM_PATHS],
    output logic              restart
);
    path_cfg_t cfg_q [NUM_PATHS];

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_field
        localparam int DL = div_lsb(g);
        localparam int SL = sel_lsb(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (we) begin
                cfg_q[g].div <= wdata[DL +: DIV_W];
                cfg_q[g].sel <= wdata[SL +: SEL_W];
            end
        end

        assign cfg[g] = cfg_q[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PATHS; i++) begin
            rdata[div_lsb(i) +: DIV_W] = cfg_q[i].div;
            rdata[sel_lsb(i) +: SEL_W] = cfg_q[i].sel;
        end
    end

    assign restart = we;
endmodule

// File: rtl/clkgen_prescaler.sv
module clkgen_prescaler
    import clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_CNT_W-1:0] cnt;
    logic [PRE_CNT_W-1:0] last;

    assign last = pre_last(sel);
    assign tick = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider
    import clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [DIV_W-1:0] div,
    output logic             done
);
    logic [DIV_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == div - 1'b1);
    assign done   = step && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clkgen_path.sv
module clkgen_path
    import clkgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  path_cfg_t cfg,
    output logic      strobe
);
    logic en;
    logic hold;
    logic pre_tick;
    logic div_done;

    assign en   = path_enabled(cfg);
    assign hold = restart || !en;

    clkgen_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (hold),
        .sel   (cfg.sel),
        .tick  (pre_tick)
    );

    clkgen_divider u_div (
        .clk   (clk),
        .rst   (rst),
        .clear (hold),
        .step  (pre_tick),
        .div   (cfg.div),
        .done  (div_done)
    );

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            strobe <= 1'b0;
        end else begin
            strobe <= en && div_done;
        end
    end
endmodule

// File: rtl/pwm_clk_enable_gen.sv
module pwm_clk_enable_gen
    import clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              tick_a,
    output logic              tick_b
);
    path_cfg_t             cfg [NUM_PATHS];
    logic                  restart;
    logic [NUM_PATHS-1:0]  ticks;

    clkgen_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .cfg     (cfg),
        .restart (restart)
    );

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
        clkgen_path u_path (
            .clk     (clk),
            .rst     (rst),
            .restart (restart),
            .cfg     (cfg[g]),
            .strobe  (ticks[g])
        );
    end

    assign tick_a = ticks[0];
    assign tick_b = ticks[1];
endmodule

// File: rtl/clkgen_checker.sv
module clkgen_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        tick_a,
    input logic        tick_b
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_rdata == 32'd0) && !tick_a && !tick_b);

    assert_a_fields_R2: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_we) |-> cfg_rdata[11:0] == $past(cfg_wdata[11:0]));

    assert_b_fields_R3: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_we) |-> cfg_rdata[27:16] == $past(cfg_wdata[27:16]));

    assert_one_cycle_a_R5: assert property (@(posedge clk) disable iff (rst)
        (tick_a && !(cfg_rdata[7:0] == 8'd1 && cfg_rdata[11:8] == 4'd0)) |=> !tick_a);

    assert_one_cycle_b_R5: assert property (@(posedge clk) disable iff (rst)
        (tick_b && !(cfg_rdata[23:16] == 8'd1 && cfg_rdata[27:24] == 4'd0)) |=> !tick_b);

    assert_div_zero_a_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[7:0] == 8'd0) |-> !tick_a);

    assert_div_zero_b_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[23:16] == 8'd0) |-> !tick_b);

    assert_reserved_a_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[11:8] > 4'd10) |-> !tick_a);

    assert_reserved_b_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[27:24] > 4'd10) |-> !tick_b);

    assert_write_clears_R8: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_we) |-> !tick_a && !tick_b);
endmodule

bind pwm_clk_enable_gen clkgen_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .tick_a    (tick_a),
    .tick_b    (tick_b)
);

// File: tb/tb_pwm_clk_enable_gen.sv
module tb_pwm_clk_enable_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tick_a;
    logic        tick_b;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    int    qa[$];
    int    qb[$];
    string tag_a = "R1";
    string tag_b = "R1";

    pwm_clk_enable_gen dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tick_a    (tick_a),
        .tick_b    (tick_b)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare observed strobes against the expected-cycle queues
    always @(negedge clk) begin
        if (!rst) begin
            automatic bit ea = (qa.size() > 0) && (qa[0] == cyc);
            automatic bit eb = (qb.size() > 0) && (qb[0] == cyc);
            if (tick_a || ea) begin
                checks++;
                if (tick_a !== ea) begin
                    errors++;
                    $display("FAIL %s tick_a at cycle %0d: actual %0b expected %0b", tag_a, cyc, tick_a, ea);
                end
                if (ea) void'(qa.pop_front());
            end
            if (tick_b || eb) begin
                checks++;
                if (tick_b !== eb) begin
                    errors++;
                    $display("FAIL %s tick_b at cycle %0d: actual %0b expected %0b", tag_b, cyc, tick_b, eb);
                end
                if (eb) void'(qb.pop_front());
            end
        end
    end

    function automatic int period_of(input logic [3:0] sel, input logic [7:0] dv);
        if (dv == 8'd0 || sel > 4'd10) return 0;
        return (1 << sel) * int'(dv);
    endfunction

    // Driver: write a word, check readback, queue expected strobes for a window
    task automatic run_cfg(input logic [31:0] word, input int window, input string ta, input string tb_tag);
        automatic logic [31:0] exp_rd = word & 32'h0FFF_0FFF;
        automatic int pa = period_of(word[11:8], word[7:0]);
        automatic int pb = period_of(word[27:24], word[23:16]);
        automatic int c0;
        cfg_wdata = word;
        cfg_we    = 1'b1;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        c0 = cyc;
        qa.delete();
        qb.delete();
        tag_a = ta;
        tag_b = tb_tag;
        if (pa > 0) for (int k = 1; k * pa <= window; k++) qa.push_back(c0 + k * pa);
        if (pb > 0) for (int k = 1; k * pb <= window; k++) qb.push_back(c0 + k * pb);
        checks++;
        if (cfg_rdata !== exp_rd) begin
            errors++;
            $display("FAIL R2/R3 readback: actual %h expected %h", cfg_rdata, exp_rd);
        end
        repeat (window + 1) @(negedge clk);
        #1;
        checks++;
        if (qa.size() != 0) begin
            errors++;
            $display("FAIL %s path A missing strobes: actual %0d left expected 0", ta, qa.size());
        end
        checks++;
        if (qb.size() != 0) begin
            errors++;
            $display("FAIL %s path B missing strobes: actual %0d left expected 0", tb_tag, qb.size());
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (cfg_rdata !== 32'd0 || tick_a !== 1'b0 || tick_b !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: actual %h/%0b/%0b expected 0/0/0", cfg_rdata, tick_a, tick_b);
        end
        repeat (40) @(negedge clk);  // R1: any strobe here is caught by the monitor
        #1;
        // R4 / R9: A period 5, B off
        run_cfg(32'h0000_0005, 60, "R4", "R9");
        // R3 / R9: A sel 2 div 3 (12), B sel 1 div 7 (14)
        run_cfg(32'h0107_0203, 200, "R9", "R3");
        // R5: A period 1 (every cycle), B sel 3 div 2 (16)
        run_cfg(32'h0302_0001, 20, "R5", "R5");
        // R6 on A (div 0), R7 on B (sel 11)
        run_cfg(32'h0B09_0A00, 300, "R6", "R7");
        // R7 on A (sel 15), R6 on B (div 0)
        run_cfg(32'h0500_0F04, 300, "R7", "R6");
        // R4 at the top prescaler: A sel 10 div 3 (3072), B sel 4 div 255 (4080)
        run_cfg(32'h04FF_0A03, 8200, "R4", "R4");
        // R8: rewrite the same word before the first strobe; the interval restarts
        run_cfg(32'h0000_0105, 7, "R8", "R8");
        run_cfg(32'h0000_0105, 25, "R8", "R8");
        // R2 / R3: unused bits dropped, both paths period 240
        run_cfg(32'hF0F0_F0F0, 500, "R2", "R3");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule